// File: doc/BRIEF.md
# Pin Controller with Per-Pin Interrupt Detection

This block is a memory-mapped general-purpose pin controller for eight to twelve pins. A host reaches it over a plain word-addressed register port with separate read and write strobes. Software can drive each pin as an output from a data register or leave it as an input. It can sample the pins through a two-flop synchronizer, and it can arm a per-pin interrupt detector that responds to a rising edge, a falling edge, either edge, a high level or a low level.

Each pin has an enable bit, a mask bit and a pending bit. An enabled pin sets its pending bit when its detector fires. The pending bit stays set until software acknowledges it by writing a one. The mask bits hide a pin from the status view and from the single combined interrupt line, but they leave the pending bit itself unchanged. A raw view of the pending bits is always readable. A self-clearing software reset is not used. Instead, a held reset bit clears the programmable state while it is one, and normal operation resumes once it is written back to zero.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After the reset input is released, every register reads zero, `pin_oe` is zero and `irq_out` is low.
- R2: Word offsets 11, 12, 13 and offset 3 always read zero, and `bus_rdata` is zero in any cycle where `bus_rd` is low.
- R3: Offset 8 holds the direction bits and offset 6 holds the output data bits. `pin_oe` equals the direction register, where 1 means output, and `pin_out` equals the output data register. Both take effect on the clock edge that samples the write.
- R4: Offset 7 reads the pins through a two-flop synchronizer. A change on `pin_in` made before clock edge k is visible after edge k+1 and not before.
- R5: Interrupt codes 0 (falling edge), 1 (rising edge) and 4 (either edge) compare each synchronized sample with the one before it. The pending bit is set on the third clock edge after the pin change.
- R6: Code 2 (level low) and code 3 (level high) assert the pending bit on every cycle in which the level is active, so an acknowledge issued while the level persists leaves the bit set. Codes 5, 6 and 7 never set a pending bit.
- R7: The 3-bit code of pin p sits in bits [4p+2:4p] of offset 9 for p below 8, and in bits [4(p-8)+2:4(p-8)] of offset 10 for p of 8 and above. Bit 3 of every slot, and every slot without a pin, reads zero.
- R8: A pending bit is set only while the enable bit at offset 0 is 1. Clearing the enable bit leaves an existing pending bit unchanged.
- R9: Writing 1s to offset 4 sets mask bits, and writing 1s to offset 5 clears them. Zero bits have no effect, and both offsets read the current mask. Offset 1 reads the pending bits ANDed with the inverted mask, and offset 2 reads the raw pending bits.
- R10: Writing 1s to offset 3 clears the matching pending bits. If a detector fires in the same cycle that its pin is acknowledged, the pending bit stays set.
- R11: `irq_out` is high exactly when at least one pending bit is unmasked.
- R12: Register bits at or above NUM_PINS read zero, and writes to them are ignored.
- R13: Bit 0 of offset 15 is a held reset. While it reads 1, all of the following return to zero on the next edge and ignore writes: enable, mask, pending, output data, direction, mode and use-select. Writing 0 releases it.
- R14: Offset 14 is a use-select register whose bits are stored, read back and driven on `pin_use`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 4 | Word offset |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, combinational from offset |
| pin_in | input | NUM_PINS | Pin levels from the pads |
| pin_out | output | NUM_PINS | Output data to the pads |
| pin_oe | output | NUM_PINS | Output enable per pin |
| pin_use | output | NUM_PINS | Use-select bits |
| irq_out | output | 1 | Combined interrupt |

## Verification
The acknowledge write and a detector hit can land on the same pin in the same clock cycle. To provoke this, the bench toggles a pin that is set to either-edge mode. It then times the write to offset 3 so that the write is sampled on the third edge after the toggle, the same edge where the synchronized edge sets the pending bit. The raw pending view must still show that bit after the write. A later acknowledge with no edge present must clear it. A cycle-by-cycle behavioural model, with its own sampling queue and mode table, is compared on every clock against the outputs and any read data.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

   localparam int unsigned ADDR_W    = 4;
   localparam int unsigned CODE_W    = 3;
   localparam int unsigned SLOT_W    = 4;
   localparam int unsigned LO_SLOTS  = 8;

   typedef enum logic [CODE_W-1:0] {
      TRIG_FALL = 3'd0,
      TRIG_RISE = 3'd1,
      TRIG_LOW  = 3'd2,
      TRIG_HIGH = 3'd3,
      TRIG_BOTH = 3'd4
   } trig_e;

   localparam logic [ADDR_W-1:0] OFS_ENABLE  = 4'd0;
   localparam logic [ADDR_W-1:0] OFS_STATUS  = 4'd1;
   localparam logic [ADDR_W-1:0] OFS_RAW     = 4'd2;
   localparam logic [ADDR_W-1:0] OFS_ACK     = 4'd3;
   localparam logic [ADDR_W-1:0] OFS_MSET    = 4'd4;
   localparam logic [ADDR_W-1:0] OFS_MCLR    = 4'd5;
   localparam logic [ADDR_W-1:0] OFS_DOUT    = 4'd6;
   localparam logic [ADDR_W-1:0] OFS_DIN     = 4'd7;
   localparam logic [ADDR_W-1:0] OFS_DIR     = 4'd8;
   localparam logic [ADDR_W-1:0] OFS_MODE_LO = 4'd9;
   localparam logic [ADDR_W-1:0] OFS_MODE_HI = 4'd10;
   localparam logic [ADDR_W-1:0] OFS_USE     = 4'd14;
   localparam logic [ADDR_W-1:0] OFS_HOLD    = 4'd15;

endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
   parameter int unsigned WIDTH  = 12,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o,
   output logic [WIDTH-1:0] prev_o
);

   logic [WIDTH-1:0] stage_q [STAGES];
   logic [WIDTH-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
         prev_q <= '0;
      end else begin
         stage_q[0] <= async_i;
         for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
         prev_q <= stage_q[STAGES-1];
      end
   end

   assign sync_o = stage_q[STAGES-1];
   assign prev_o = prev_q;

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
   import gpio_irq_pkg::*;
#(
   parameter int unsigned WIDTH = 12
) (
   input  logic [WIDTH-1:0]             cur_i,
   input  logic [WIDTH-1:0]             prev_i,
   input  logic [WIDTH-1:0][CODE_W-1:0] mode_i,
   output logic [WIDTH-1:0]             hit_o
);

   for (genvar p = 0; p < WIDTH; p++) begin : g_pin
      always_comb begin
         case (mode_i[p])
            TRIG_FALL: hit_o[p] = ~cur_i[p] &  prev_i[p];
            TRIG_RISE: hit_o[p] =  cur_i[p] & ~prev_i[p];
            TRIG_LOW:  hit_o[p] = ~cur_i[p];
            TRIG_HIGH: hit_o[p] =  cur_i[p];
            TRIG_BOTH: hit_o[p] =  cur_i[p] ^  prev_i[p];
            default:   hit_o[p] = 1'b0;
         endcase
      end
   end

endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
   import gpio_irq_pkg::*;
#(
   parameter int unsigned NUM_PINS = 12,
   parameter int unsigned DW       = 32
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            wr_i,
   input  logic                            rd_i,
   input  logic [ADDR_W-1:0]               addr_i,
   input  logic [DW-1:0]                   wdata_i,
   output logic [DW-1:0]                   rdata_o,
   input  logic [NUM_PINS-1:0]             hit_i,
   input  logic [NUM_PINS-1:0]             din_i,
   output logic [NUM_PINS-1:0]             en_o,
   output logic [NUM_PINS-1:0]             mask_o,
   output logic [NUM_PINS-1:0]             pend_o,
   output logic [NUM_PINS-1:0]             dout_o,
   output logic [NUM_PINS-1:0]             dir_o,
   output logic [NUM_PINS-1:0]             use_o,
   output logic [NUM_PINS-1:0][CODE_W-1:0] mode_o,
   output logic                            hold_o
);

   localparam int unsigned HI_SLOTS = NUM_PINS - LO_SLOTS;

   logic [NUM_PINS-1:0] en_q, mask_q, pend_q, dout_q, dir_q, use_q;
   logic                hold_q;
   logic [NUM_PINS-1:0] wbits;
   logic [NUM_PINS-1:0] ack_bits;
   logic                unused_wdata;

   assign wbits        = wdata_i[NUM_PINS-1:0];
   assign ack_bits     = (wr_i && addr_i == OFS_ACK) ? wbits : '0;
   assign unused_wdata = ^wdata_i;

   function automatic logic hit_ofs(input logic [ADDR_W-1:0] ofs);
      return wr_i && (addr_i == ofs);
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= 1'b0;
      end else if (hit_ofs(OFS_HOLD)) begin
         hold_q <= wdata_i[0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= '0;
         mask_q <= '0;
         pend_q <= '0;
         dout_q <= '0;
         dir_q  <= '0;
         use_q  <= '0;
      end else if (hold_q) begin
         en_q   <= '0;
         mask_q <= '0;
         pend_q <= '0;
         dout_q <= '0;
         dir_q  <= '0;
         use_q  <= '0;
      end else begin
         pend_q <= (pend_q & ~ack_bits) | (hit_i & en_q);
         if (hit_ofs(OFS_ENABLE)) en_q   <= wbits;
         if (hit_ofs(OFS_MSET))   mask_q <= mask_q | wbits;
         if (hit_ofs(OFS_MCLR))   mask_q <= mask_q & ~wbits;
         if (hit_ofs(OFS_DOUT))   dout_q <= wbits;
         if (hit_ofs(OFS_DIR))    dir_q  <= wbits;
         if (hit_ofs(OFS_USE))    use_q  <= wbits;
      end
   end

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_slot
      localparam int unsigned BASE = (p < LO_SLOTS) ? p * SLOT_W : (p - LO_SLOTS) * SLOT_W;
      localparam logic [ADDR_W-1:0] OWN_OFS = (p < LO_SLOTS) ? OFS_MODE_LO : OFS_MODE_HI;
      logic [CODE_W-1:0] code_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            code_q <= '0;
         end else if (hold_q) begin
            code_q <= '0;
         end else if (hit_ofs(OWN_OFS)) begin
            code_q <= wdata_i[BASE +: CODE_W];
         end
      end

      assign mode_o[p] = code_q;
   end

   logic [DW-1:0] mode_lo_rd, mode_hi_rd;

   always_comb begin
      mode_lo_rd = '0;
      for (int s = 0; s < LO_SLOTS; s++) mode_lo_rd[s*SLOT_W +: CODE_W] = mode_o[s];
   end

   always_comb begin
      mode_hi_rd = '0;
      for (int s = 0; s < HI_SLOTS; s++) mode_hi_rd[s*SLOT_W +: CODE_W] = mode_o[s + LO_SLOTS];
   end

   always_comb begin
      rdata_o = '0;
      if (rd_i) begin
         case (addr_i)
            OFS_ENABLE:  rdata_o = DW'(en_q);
            OFS_STATUS:  rdata_o = DW'(pend_q & ~mask_q);
            OFS_RAW:     rdata_o = DW'(pend_q);
            OFS_MSET,
            OFS_MCLR:    rdata_o = DW'(mask_q);
            OFS_DOUT:    rdata_o = DW'(dout_q);
            OFS_DIN:     rdata_o = DW'(din_i);
            OFS_DIR:     rdata_o = DW'(dir_q);
            OFS_MODE_LO: rdata_o = mode_lo_rd;
            OFS_MODE_HI: rdata_o = mode_hi_rd;
            OFS_USE:     rdata_o = DW'(use_q);
            OFS_HOLD:    rdata_o = DW'(hold_q);
            default:     rdata_o = '0;
         endcase
      end
   end

   assign en_o   = en_q;
   assign mask_o = mask_q;
   assign pend_o = pend_q;
   assign dout_o = dout_q;
   assign dir_o  = dir_q;
   assign use_o  = use_q;
   assign hold_o = hold_q;

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
   import gpio_irq_pkg::*;
#(
   parameter int unsigned NUM_PINS    = 12,
   parameter int unsigned DW          = 32,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_wr,
   input  logic                bus_rd,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [DW-1:0]       bus_wdata,
   output logic [DW-1:0]       bus_rdata,
   input  logic [NUM_PINS-1:0] pin_in,
   output logic [NUM_PINS-1:0] pin_out,
   output logic [NUM_PINS-1:0] pin_oe,
   output logic [NUM_PINS-1:0] pin_use,
   output logic                irq_out
);

   if (NUM_PINS < LO_SLOTS || NUM_PINS > 2 * LO_SLOTS - 4) begin : g_bad_pins
      $error("gpio_irq_ctrl: NUM_PINS must lie in 8..12");
   end
   if (DW < LO_SLOTS * SLOT_W) begin : g_bad_dw
      $error("gpio_irq_ctrl: DW too narrow for eight mode slots");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("gpio_irq_ctrl: SYNC_STAGES must be at least 2");
   end

   logic [NUM_PINS-1:0]             sync_w, prev_w, evt_w;
   logic [NUM_PINS-1:0]             en_w, mask_w, pend_w, dout_w, dir_w;
   logic [NUM_PINS-1:0][CODE_W-1:0] mode_w;
   logic                            srst_w;

   gpio_irq_sync #(
      .WIDTH  (NUM_PINS),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (pin_in),
      .sync_o  (sync_w),
      .prev_o  (prev_w)
   );

   gpio_irq_detect #(
      .WIDTH (NUM_PINS)
   ) u_detect (
      .cur_i  (sync_w),
      .prev_i (prev_w),
      .mode_i (mode_w),
      .hit_o  (evt_w)
   );

   gpio_irq_regs #(
      .NUM_PINS (NUM_PINS),
      .DW       (DW)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_i    (bus_wr),
      .rd_i    (bus_rd),
      .addr_i  (bus_addr),
      .wdata_i (bus_wdata),
      .rdata_o (bus_rdata),
      .hit_i   (evt_w),
      .din_i   (sync_w),
      .en_o    (en_w),
      .mask_o  (mask_w),
      .pend_o  (pend_w),
      .dout_o  (dout_w),
      .dir_o   (dir_w),
      .use_o   (pin_use),
      .mode_o  (mode_w),
      .hold_o  (srst_w)
   );

   assign pin_out = dout_w;
   assign pin_oe  = dir_w;
   assign irq_out = |(pend_w & ~mask_w);

endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk
   import gpio_irq_pkg::*;
#(
   parameter int unsigned NUM_PINS = 12,
   parameter int unsigned DW       = 32
) (
   input logic                clk,
   input logic                rst_n,
   input logic                bus_wr,
   input logic                bus_rd,
   input logic [ADDR_W-1:0]   bus_addr,
   input logic [DW-1:0]       bus_wdata,
   input logic [DW-1:0]       bus_rdata,
   input logic [NUM_PINS-1:0] pin_oe,
   input logic                irq_out,
   input logic [NUM_PINS-1:0] en,
   input logic [NUM_PINS-1:0] mask,
   input logic [NUM_PINS-1:0] pend,
   input logic [NUM_PINS-1:0] evt,
   input logic                srst
);

   assert_status_vs_irq_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == OFS_STATUS) |-> ((bus_rdata != '0) == irq_out));

   assert_dir_drives_oe_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == OFS_DIR && !srst) |=> (pin_oe == $past(bus_wdata[NUM_PINS-1:0])));

   assert_mask_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == OFS_MSET && !srst)
      |=> ((mask & $past(bus_wdata[NUM_PINS-1:0])) == $past(bus_wdata[NUM_PINS-1:0])));

   assert_mask_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == OFS_MCLR && !srst)
      |=> ((mask & $past(bus_wdata[NUM_PINS-1:0])) == '0));

   assert_ack_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == OFS_ACK && !srst)
      |=> ((pend & $past(bus_wdata[NUM_PINS-1:0] & ~evt)) == '0));

   assert_enable_gates_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !srst |=> ((pend & ~$past(pend) & ~$past(en)) == '0));

   assert_hold_clears_R13: assert property (@(posedge clk) disable iff (!rst_n)
      srst |=> (en == '0 && mask == '0 && pend == '0 && pin_oe == '0));

   assert_upper_bits_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr != OFS_MODE_LO && bus_addr != OFS_MODE_HI)
      |-> ((bus_rdata >> NUM_PINS) == '0));

endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(
   .NUM_PINS (NUM_PINS),
   .DW       (DW)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_wr    (bus_wr),
   .bus_rd    (bus_rd),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .pin_oe    (pin_oe),
   .irq_out   (irq_out),
   .en        (en_w),
   .mask      (mask_w),
   .pend      (pend_w),
   .evt       (evt_w),
   .srst      (srst_w)
);

// File: tb/gpio_irq_ctrl_test.sv
`timescale 1ns/1ps
module gpio_irq_ctrl_test;

   localparam int N  = 12;
   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_wr = 1'b0, bus_rd = 1'b0;
   logic [3:0]    bus_addr = '0;
   logic [DW-1:0] bus_wdata = '0;
   logic [DW-1:0] bus_rdata;
   logic [N-1:0]  pin_in = '0;
   logic [N-1:0]  pin_out, pin_oe, pin_use;
   logic          irq_out;

   int n_cmp = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   gpio_irq_ctrl #(.NUM_PINS(N), .DW(DW)) uut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
      .pin_use(pin_use), .irq_out(irq_out)
   );

   // ---------------- behavioural reference model ----------------
   logic [N-1:0] m_en, m_mask, m_pend, m_dout, m_dir, m_use;
   logic [N-1:0] m_q [$];     // sampling queue: [0] newest, [1] synchronized, [2] previous
   int           m_mode [N];
   bit           m_hold;

   function automatic bit fires(int code, bit cur, bit old);
      case (code)
         0: return !cur && old;
         1: return cur && !old;
         2: return !cur;
         3: return cur;
         4: return cur != old;
         default: return 1'b0;
      endcase
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_en = '0; m_mask = '0; m_pend = '0; m_dout = '0; m_dir = '0; m_use = '0;
         m_hold = 1'b0;
         m_q = {12'h0, 12'h0, 12'h0};
         for (int p = 0; p < N; p++) m_mode[p] = 0;
      end else begin
         logic [N-1:0] nxt;
         bit nxt_hold;
         nxt = m_pend;
         for (int p = 0; p < N; p++) begin
            if (bus_wr && bus_addr == 3 && bus_wdata[p]) nxt[p] = 1'b0;
            if (m_en[p] && fires(m_mode[p], m_q[1][p], m_q[2][p])) nxt[p] = 1'b1;
         end
         nxt_hold = (bus_wr && bus_addr == 15) ? bus_wdata[0] : m_hold;
         if (m_hold) begin
            m_en = '0; m_mask = '0; m_pend = '0; m_dout = '0; m_dir = '0; m_use = '0;
            for (int p = 0; p < N; p++) m_mode[p] = 0;
         end else begin
            m_pend = nxt;
            if (bus_wr) begin
               case (bus_addr)
                  0:  m_en   = bus_wdata[N-1:0];
                  4:  m_mask = m_mask | bus_wdata[N-1:0];
                  5:  m_mask = m_mask & ~bus_wdata[N-1:0];
                  6:  m_dout = bus_wdata[N-1:0];
                  8:  m_dir  = bus_wdata[N-1:0];
                  9:  for (int p = 0; p < 8; p++) m_mode[p] = (bus_wdata >> (4*p)) & 7;
                  10: for (int p = 8; p < N; p++) m_mode[p] = (bus_wdata >> (4*(p-8))) & 7;
                  14: m_use  = bus_wdata[N-1:0];
                  default: ;
               endcase
            end
         end
         m_hold = nxt_hold;
         m_q.push_front(pin_in);
         void'(m_q.pop_back());
      end
   end

   function automatic logic [31:0] exp_rd(logic [3:0] a);
      logic [31:0] v;
      v = '0;
      case (a)
         0: v = 32'(m_en);
         1: v = 32'(m_pend & ~m_mask);
         2: v = 32'(m_pend);
         4, 5: v = 32'(m_mask);
         6: v = 32'(m_dout);
         7: v = 32'(m_q[1]);
         8: v = 32'(m_dir);
         9: for (int p = 0; p < 8; p++) v = v | (32'(m_mode[p]) << (4*p));
         10: for (int p = 8; p < N; p++) v = v | (32'(m_mode[p]) << (4*(p-8)));
         14: v = 32'(m_use);
         15: v = 32'(m_hold);
         default: v = '0;
      endcase
      return v;
   endfunction

   function automatic string tag_of(logic [3:0] a);
      case (a)
         0: return "R8";
         1, 2, 4, 5: return "R9";
         3, 11, 12, 13: return "R2";
         6, 8: return "R3";
         7: return "R4";
         9, 10: return "R7";
         14: return "R14";
         default: return "R13";
      endcase
   endfunction

   task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s at %0t: actual=%h expected=%h", tag, $time, act, exp);
      end
   endtask

   // per-clock comparison, well away from both clock edges
   always @(posedge clk) begin
      #4;
      if (rst_n) begin
         chk(pin_oe == m_dir, "R3", 32'(pin_oe), 32'(m_dir));
         chk(pin_out == m_dout, "R3", 32'(pin_out), 32'(m_dout));
         chk(pin_use == m_use, "R14", 32'(pin_use), 32'(m_use));
         chk(irq_out == |(m_pend & ~m_mask), "R11", 32'(irq_out), 32'(|(m_pend & ~m_mask)));
         if (bus_rd) chk(bus_rdata == exp_rd(bus_addr), tag_of(bus_addr), bus_rdata, exp_rd(bus_addr));
         else        chk(bus_rdata == '0, "R2", bus_rdata, 32'h0);
      end
   end

   // ---------------- stimulus ----------------
   task automatic wr_reg(logic [3:0] a, logic [31:0] d);
      @(negedge clk);
      bus_rd = 1'b0; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd_reg(logic [3:0] a, output logic [31:0] v);
      @(negedge clk);
      bus_wr = 1'b0; bus_rd = 1'b1; bus_addr = a;
      #1 v = bus_rdata;
   endtask

   task automatic expect_rd(logic [3:0] a, logic [31:0] exp, string tag);
      logic [31:0] v;
      rd_reg(a, v);
      chk(v == exp, tag, v, exp);
   endtask

   task automatic idle(int n);
      repeat (n) begin
         @(negedge clk);
         bus_wr = 1'b0; bus_rd = 1'b0;
      end
   endtask

   task automatic drive_pins(logic [N-1:0] v);
      @(negedge clk);
      bus_wr = 1'b0; bus_rd = 1'b0;
      pin_in = v;
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 / R2: reset values and reserved words
      for (int a = 0; a < 16; a++) expect_rd(4'(a), 32'h0, (a >= 11 && a <= 13) ? "R2" : "R1");
      chk(pin_oe == '0, "R1", 32'(pin_oe), 32'h0);
      chk(irq_out == 1'b0, "R1", 32'(irq_out), 32'h0);

      // R3 / R12 / R14: direction, output data, unused upper bits, use-select
      wr_reg(6, 32'hFFFF_FFFF);
      wr_reg(8, 32'h0000_00F0);
      expect_rd(6, 32'h0000_0FFF, "R12");
      expect_rd(8, 32'h0000_00F0, "R3");
      chk(pin_oe == 12'h0F0, "R3", 32'(pin_oe), 32'h0F0);
      chk(pin_out == 12'hFFF, "R3", 32'(pin_out), 32'hFFF);
      wr_reg(14, 32'h000A_BCDE);
      expect_rd(14, 32'h0000_0CDE, "R14");
      chk(pin_use == 12'hCDE, "R14", 32'(pin_use), 32'hCDE);

      // R4: two-flop input latency
      drive_pins(12'hA5A);
      expect_rd(7, 32'h0, "R4");
      expect_rd(7, 32'h0000_0A5A, "R4");
      drive_pins(12'h000);
      idle(4);

      // R7: slot layout, bit 3 and absent slots read zero
      wr_reg(9, 32'h99DC_BA98);
      expect_rd(9, 32'h1154_3210, "R7");
      wr_reg(10, 32'hFFFF_1111);
      expect_rd(10, 32'h0000_1111, "R7");

      // R8: disabled pins never become pending
      drive_pins(12'h002);
      idle(4);
      expect_rd(2, 32'h0, "R8");

      // R5 / R11: rising edge on pin 1
      wr_reg(0, 32'h002);
      drive_pins(12'h000);
      idle(3);
      drive_pins(12'h002);
      idle(4);
      expect_rd(2, 32'h002, "R5");
      expect_rd(1, 32'h002, "R9");
      chk(irq_out == 1'b1, "R11", 32'(irq_out), 32'h1);

      // R9: mask set / clear with zero bits ignored
      wr_reg(4, 32'h002);
      expect_rd(1, 32'h0, "R9");
      expect_rd(2, 32'h002, "R9");
      chk(irq_out == 1'b0, "R11", 32'(irq_out), 32'h0);
      wr_reg(5, 32'h001);
      expect_rd(4, 32'h002, "R9");
      wr_reg(5, 32'h002);
      expect_rd(5, 32'h0, "R9");
      chk(irq_out == 1'b1, "R11", 32'(irq_out), 32'h1);

      // R10: acknowledge
      wr_reg(3, 32'h002);
      expect_rd(2, 32'h0, "R10");
      chk(irq_out == 1'b0, "R11", 32'(irq_out), 32'h0);

      // R6 / R8: level low on pin 2 survives acknowledge; disabling keeps pending
      wr_reg(0, 32'h004);
      idle(2);
      expect_rd(2, 32'h004, "R6");
      wr_reg(3, 32'h004);
      idle(1);
      expect_rd(2, 32'h004, "R6");
      wr_reg(0, 32'h000);
      expect_rd(2, 32'h004, "R8");
      wr_reg(3, 32'h004);
      expect_rd(2, 32'h0, "R10");

      // R6: code 5 on pin 5 never fires
      wr_reg(0, 32'h020);
      drive_pins(12'h022);
      idle(4);
      drive_pins(12'h002);
      idle(4);
      expect_rd(2, 32'h0, "R6");
      wr_reg(0, 32'h000);

      // R5 / R7: falling (pin 0), both (pin 4), rising in upper register (pin 8)
      wr_reg(0, 32'h111);
      drive_pins(12'h113);
      idle(4);
      expect_rd(2, 32'h110, "R5");
      wr_reg(3, 32'h110);
      expect_rd(2, 32'h0, "R10");
      drive_pins(12'h002);
      idle(4);
      expect_rd(2, 32'h011, "R5");

      // R10: acknowledge sampled on the same edge as a new hit on pin 4
      drive_pins(12'h012);
      idle(1);
      wr_reg(3, 32'h010);
      expect_rd(2, 32'h011, "R10");
      wr_reg(3, 32'h011);
      expect_rd(2, 32'h0, "R10");

      // R12: enable upper bits ignored
      wr_reg(0, 32'hFFFF_FFFF);
      expect_rd(0, 32'h0000_0FFF, "R12");
      wr_reg(0, 32'h0);
      wr_reg(3, 32'hFFF);

      // R13: held reset
      wr_reg(15, 32'h1);
      expect_rd(15, 32'h1, "R13");
      expect_rd(0, 32'h0, "R13");
      expect_rd(6, 32'h0, "R13");
      wr_reg(8, 32'h00F);
      expect_rd(8, 32'h0, "R13");
      chk(pin_oe == '0, "R13", 32'(pin_oe), 32'h0);
      wr_reg(15, 32'h0);
      expect_rd(15, 32'h0, "R13");
      expect_rd(9, 32'h0, "R13");
      wr_reg(8, 32'h00F);
      expect_rd(8, 32'h00F, "R13");
      chk(pin_oe == 12'h00F, "R3", 32'(pin_oe), 32'h00F);

      idle(3);
      finish_run();
   end

endmodule